// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees a two-wire bus on which a target device is stuck holding the data line low, usually because it was interrupted in the middle of a byte. On a recovery request it holds the main bus controller in reset and releases both lines. After the sampled lines settle it tests whether clock and data both read high. If they do not, it pulls the clock low for a fixed hold time and then releases it, so that the target can finish shifting out its byte and let go of the data line. Before every further pulse it tests the bus again.

The pulse train is bounded. It stops at the first test that finds a free bus, or after a fixed number of pulses followed by one last test. The block then lets the controller out of reset, issues a single-cycle reinitialise pulse, and reports whether the bus ended up free. The line inputs pass through a two-flop synchroniser before they are tested. Both drive enables follow the open-drain convention, so a 1 pulls the line low. Sending a STOP condition afterwards is left to the controller.

Top module: `i2c_unstick`

## Requirements
- R1: While reset is asserted and in the first idle cycles after it, `scl_pull_o`, `sda_pull_o`, `ctl_hold_o`, `done_o`, `reinit_o` and `bus_ok_o` are all 0.
- R2: A request taken while idle raises `ctl_hold_o` on the next clock edge and keeps it high until the finish cycle. While `ctl_hold_o` is low, the clock is never pulled.
- R3: If both lines read high at the first test, no clock pulse is produced. The finish cycle comes SETTLE+1 = 4 cycles after the request edge, with `bus_ok_o` = 1.
- R4: Each clock pulse holds `scl_pull_o` at 1 for exactly HOLD = CLK_HZ/1e6 × HOLD_US cycles (50 with default parameters). After each pulse the clock is released for SETTLE = 3 cycles, and the bus is tested in the cycle that follows. The first test comes after the same 3 released cycles.
- R5: Pulsing stops at the first test that finds both synchronised lines high. The number of pulses then equals the number the target needed before releasing the data line.
- R6: At most MAX_TRIES pulses (100 by default) are produced. After the last pulse one more test is made. `bus_ok_o` is 1 if that test finds the bus free and 0 otherwise. A clock line that stays low counts as a bus that is not free.
- R7: The finish cycle is a single cycle in which `done_o` and `reinit_o` are both 1 and `ctl_hold_o` is 0. In the cycle before it, `ctl_hold_o` is 1.
- R8: `sda_pull_o` is never 1. The sequencer only releases the data line.
- R9: A request asserted while recovery is running is ignored. The pulse schedule and the finish cycle are unchanged.
- R10: `bus_ok_o` is cleared on the edge that takes a request. It takes the result on the edge into the finish cycle and then holds that value until the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_req_i | input | 1 | Recovery request, taken while idle |
| scl_in_i | input | 1 | Raw clock line level |
| sda_in_i | input | 1 | Raw data line level |
| scl_pull_o | output | 1 | Open-drain clock pull-down enable |
| sda_pull_o | output | 1 | Open-drain data pull-down enable |
| ctl_hold_o | output | 1 | Holds the main controller in reset during recovery |
| reinit_o | output | 1 | Single-cycle controller reinitialise pulse |
| done_o | output | 1 | Single-cycle completion strobe |
| bus_ok_o | output | 1 | Bus free at the end of the last recovery |

## Verification
The hardest case to reach is the boundary where the target gives up the data line exactly on the last permitted pulse, so that success depends on the final test after pulse MAX_TRIES. The bench models a target that releases the data line only after a chosen number of clock pulses, and runs it with 100 and with 101 pulses needed. It also runs a clock line held low to force the failure path. A request repeated in the middle of a run checks that the schedule is not restarted.

// File: rtl/unstick_pkg.sv
package unstick_pkg;

    typedef enum logic [2:0] {
        US_IDLE,
        US_SETTLE,
        US_TEST,
        US_PULSE,
        US_FINISH
    } us_state_e;

    localparam int unsigned US_SYNC_STAGES = 2;
    localparam int unsigned US_SETTLE_CYC  = US_SYNC_STAGES + 1;

endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = raw_i;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '1;
            else        stage_q[g] <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [WIDTH-1:0] cnt_o
);

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = clr_i ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
    import unstick_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 5_000_000,
    parameter int unsigned HOLD_US   = 10,
    parameter int unsigned MAX_TRIES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rec_req_i,
    input  logic scl_in_i,
    input  logic sda_in_i,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic ctl_hold_o,
    output logic reinit_o,
    output logic done_o,
    output logic bus_ok_o
);

    localparam int unsigned HOLD_CYC = (CLK_HZ / 1000) * HOLD_US / 1000;
    localparam int unsigned MAX_PHASE = (HOLD_CYC > US_SETTLE_CYC) ? HOLD_CYC : US_SETTLE_CYC;
    localparam int unsigned CW = $clog2(MAX_PHASE + 1);
    localparam int unsigned TW = $clog2(MAX_TRIES + 1);
    localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(US_SETTLE_CYC - 1);
    localparam logic [TW-1:0] TRY_LIMIT   = TW'(MAX_TRIES);

    typedef struct packed {
        us_state_e     st;
        logic [TW-1:0] tries;
        logic          ok;
    } us_regs_t;

    us_regs_t        cur_q, nxt_d;
    logic            tmr_clr;
    logic [CW-1:0]   tmr_cnt;
    logic [1:0]      line_sync;
    logic            bus_free;

    unstick_sync #(.WIDTH(2), .STAGES(US_SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_in_i, sda_in_i}),
        .sync_o (line_sync)
    );

    unstick_timer #(.WIDTH(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .cnt_o (tmr_cnt)
    );

    assign bus_free = &line_sync;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            US_IDLE: begin
                if (rec_req_i) begin
                    nxt_d.st    = US_SETTLE;
                    nxt_d.tries = '0;
                    nxt_d.ok    = 1'b0;
                end
            end
            US_SETTLE: begin
                if (tmr_cnt == SETTLE_LAST) nxt_d.st = US_TEST;
            end
            US_TEST: begin
                if (bus_free) begin
                    nxt_d.st = US_FINISH;
                    nxt_d.ok = 1'b1;
                end else if (cur_q.tries == TRY_LIMIT) begin
                    nxt_d.st = US_FINISH;
                    nxt_d.ok = 1'b0;
                end else begin
                    nxt_d.st    = US_PULSE;
                    nxt_d.tries = cur_q.tries + 1'b1;
                end
            end
            US_PULSE: begin
                if (tmr_cnt == HOLD_LAST) nxt_d.st = US_SETTLE;
            end
            US_FINISH: begin
                nxt_d.st = US_IDLE;
            end
            default: nxt_d.st = US_IDLE;
        endcase
        tmr_clr = (nxt_d.st != cur_q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st    <= US_IDLE;
            cur_q.tries <= '0;
            cur_q.ok    <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign scl_pull_o = (cur_q.st == US_PULSE);
    assign sda_pull_o = 1'b0;
    assign ctl_hold_o = (cur_q.st == US_SETTLE) || (cur_q.st == US_TEST) || (cur_q.st == US_PULSE);
    assign done_o     = (cur_q.st == US_FINISH);
    assign reinit_o   = (cur_q.st == US_FINISH);
    assign bus_ok_o   = cur_q.ok;

    // Checker state: length of the current low pulse and pulses in this run.
    logic [CW:0] low_run_q;
    int unsigned pulse_cnt_q;
    logic        pull_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q   <= '0;
            pulse_cnt_q <= 0;
            pull_prev_q <= 1'b0;
        end else begin
            pull_prev_q <= scl_pull_o;
            low_run_q   <= scl_pull_o ? low_run_q + 1'b1 : '0;
            if (!ctl_hold_o)                     pulse_cnt_q <= 0;
            else if (scl_pull_o && !pull_prev_q) pulse_cnt_q <= pulse_cnt_q + 1;
        end
    end

    p_no_pull_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_hold_o |-> !scl_pull_o);

    p_free_stops_pulses_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == US_TEST && bus_free) |=> (!scl_pull_o && done_o && bus_ok_o));

    p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_pull_o && pull_prev_q) |-> (low_run_q == (CW+1)'(HOLD_CYC)));

    p_pulse_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull_o && !pull_prev_q) |-> (pulse_cnt_q < MAX_TRIES));

    p_finish_after_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(ctl_hold_o) && reinit_o && !ctl_hold_o));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_run_not_restarted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_hold_o |=> (ctl_hold_o || done_o));

    p_ok_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_hold_o && !done_o && !rec_req_i) |=> $stable(bus_ok_o));

endmodule

// File: tb/tb_i2c_unstick.sv
module tb_i2c_unstick;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD   = 50;   // 5 MHz x 10 us
    localparam int SETTLE = 3;
    localparam int MAXP   = 100;
    localparam int PER    = SETTLE + 1 + HOLD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rec_req = 1'b0;
    logic scl_pull, sda_pull, ctl_hold, reinit, done, bus_ok;

    int  vectors = 0;
    int  miscompares = 0;
    int  need = 0;        // pulses the modelled target needs
    int  seen = 0;        // pulses it has received
    bit  scl_stuck = 1'b0;
    bit  pull_prev = 1'b0;
    logic exp_ok = 1'b0;

    wire scl_line = !scl_stuck && !scl_pull;
    wire sda_line = (seen >= need) && !sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_unstick dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rec_req_i  (rec_req),
        .scl_in_i   (scl_line),
        .sda_in_i   (sda_line),
        .scl_pull_o (scl_pull),
        .sda_pull_o (sda_pull),
        .ctl_hold_o (ctl_hold),
        .reinit_o   (reinit),
        .done_o     (done),
        .bus_ok_o   (bus_ok)
    );

    // Target model: counts clock pulses it receives.
    always @(posedge clk) begin
        pull_prev <= scl_pull;
        if (scl_pull && !pull_prev) seen <= seen + 1;
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " scl_pull"}, scl_pull, 1'b0);
        chk({tag, " sda_pull R8"}, sda_pull, 1'b0);
        chk({tag, " hold"}, ctl_hold, 1'b0);
        chk({tag, " done"}, done, 1'b0);
        chk({tag, " reinit"}, reinit, 1'b0);
        chk({tag, " ok"}, bus_ok, exp_ok);
    endtask

    // One recovery; re_o >= 0 repeats the request at that offset (R9).
    task automatic run(input int n_need, input bit stuck, input int re_o);
        int pulses;
        int fo;
        logic result;
        need = n_need;
        scl_stuck = stuck;
        seen = 0;
        pulses = stuck ? MAXP : ((n_need <= MAXP) ? n_need : MAXP);
        result = !stuck && (n_need <= MAXP);
        fo = pulses * PER + SETTLE + 1;
        rec_req = 1'b1;
        @(negedge clk);
        rec_req = 1'b0;
        exp_ok = 1'b0;   // R10: cleared on request
        for (int o = 0; o <= fo + 1; o++) begin
            logic e_scl;
            e_scl = (o < pulses * PER) && ((o % PER) >= SETTLE + 1);
            if (o == fo) exp_ok = result;
            chk("R4/R5/R6 scl_pull schedule", scl_pull, e_scl);
            chk("R8 sda_pull", sda_pull, 1'b0);
            chk("R2 hold", ctl_hold, (o < fo));
            chk("R7 done", done, (o == fo));
            chk("R7 reinit", reinit, (o == fo));
            chk("R6/R10 bus_ok", bus_ok, (o >= fo) ? result : 1'b0);
            rec_req = (o == re_o);
            @(negedge clk);
            rec_req = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1 in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_idle("R1 after reset");

        run(0, 1'b0, -1);      // R3: bus already free
        run(3, 1'b0, -1);      // R5: freed after three pulses
        run(1, 1'b0, 20);      // R9: request during pulse is ignored
        run(MAXP, 1'b0, -1);   // R6: freed by the last allowed pulse
        // R10: result held while idle without requests
        repeat (5) begin
            chk("R10 ok held", bus_ok, 1'b1);
            @(negedge clk);
        end
        run(MAXP + 1, 1'b0, -1); // R6: never freed, failure
        repeat (4) begin
            chk("R10 ok held after failure", bus_ok, 1'b0);
            @(negedge clk);
        end
        run(0, 1'b1, -1);      // R6: clock line stuck low
        run(2, 1'b0, -1);      // R5: recovery after a failure
        chk_idle("R1/R2 idle at end");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule